// File: doc/BRIEF.md
# Saturating Two's Complement Add/Subtract Unit

This block adds or subtracts two WIDTH-bit operands using one shared carry chain. For subtraction it feeds the bitwise inverse of the second operand into that chain and forces the carry-in high. The raw sum is correct modulo 2^WIDTH under both the signed and the unsigned reading of the bits. The block returns that sum together with the chain's final carry and a signed overflow flag.

The signed overflow flag is the XOR of the carry entering the top bit and the carry leaving it. A per-operation mode input chooses between two behaviours on signed overflow. In wrap mode the modular sum goes straight through. In clamp mode it is replaced by the extreme code on the side toward which the true result ran.

The unit holds no state. An ALU or a datapath stage uses it inside a single cycle and registers the outputs itself.

Top module: `sat_addsub`

## Requirements
- R1: With `op_sub`=0 and `sat_en`=0, `res` equals (A + B) mod 2^WIDTH.
- R2: With `op_sub`=1 and `sat_en`=0, `res` equals (A − B) mod 2^WIDTH, and `cout` is 1 exactly when A ≥ B as unsigned values, meaning no borrow.
- R3: With `op_sub`=0, `cout` is the unsigned carry out of A + B. `cout` does not depend on `sat_en`.
- R4: `ovf` is 1 exactly when the signed result of the selected operation lies outside [−2^(WIDTH−1), 2^(WIDTH−1)−1]. This holds for both operations and both modes.
- R5: At WIDTH=8 in wrap mode, 0xB4 + 0x9A gives `res`=0x4E and `ovf`=1.
- R6: 0 − (1 followed by zeros) gives back the same pattern in wrap mode, with `ovf`=1.
- R7: With `sat_en`=1 and overflow, `res` is 0 followed by ones when A's top bit is 0, and 1 followed by zeros when A's top bit is 1.
- R8: With `sat_en`=1 and no overflow, `res` equals the wrap-mode result.
- R9: `ovf` stays 1 when the result has been clamped.
- R10: At WIDTH=12 in clamp mode, 2047 + 1 gives 2047 and −2048 − 1 gives −2048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| op_sub | input | 1 | 0 = add, 1 = subtract (A − B) |
| sat_en | input | 1 | 0 = modular wrap, 1 = clamp on signed overflow |
| res | output | WIDTH | Result |
| cout | output | 1 | Raw carry out of the top bit of the shared chain |
| ovf | output | 1 | Signed overflow flag |

## Verification
The hardest case to reach is a subtraction whose inverted operand and forced carry-in ripple through every bit. Negating the most negative code is one such case: the carry into the top bit and the carry out of it must differ even though the output pattern matches the input. Clamp mode at the exact edges of the range is another. A sweep over every 8-bit operand pair, in both operations and both modes, covers these together with every other carry pattern. Directed 12-bit vectors then confirm the clamp edges at a second width.

// File: rtl/sat_addsub_pkg.sv
package sat_addsub_pkg;
  typedef enum logic {OP_ADD = 1'b0, OP_SUB = 1'b1} op_e;
  typedef enum logic {MODE_WRAP = 1'b0, MODE_CLAMP = 1'b1} mode_e;
endpackage

// File: rtl/sat_addsub_bprep.sv
// Conditions the second operand for the shared carry chain.
module sat_addsub_bprep #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] b_in,
  input  sat_addsub_pkg::op_e op,
  output logic [WIDTH-1:0] b_eff,
  output logic             c_in
);
  always_comb begin
    b_eff = (op == sat_addsub_pkg::OP_SUB) ? ~b_in : b_in;
    c_in  = (op == sat_addsub_pkg::OP_SUB);
  end
endmodule

// File: rtl/sat_addsub_chain.sv
// Bitwise ripple chain that exposes the carries around the top bit.
module sat_addsub_chain #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             c_in,
  output logic [WIDTH-1:0] sum,
  output logic             c_top_in,
  output logic             c_top_out
);
  logic [WIDTH:0] cy;
  assign cy[0] = c_in;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    assign sum[i]  = x[i] ^ y[i] ^ cy[i];
    assign cy[i+1] = (x[i] & y[i]) | (cy[i] & (x[i] ^ y[i]));
  end

  assign c_top_in  = cy[WIDTH-1];
  assign c_top_out = cy[WIDTH];
endmodule

// File: rtl/sat_addsub_clamp.sv
// Replaces the modular sum with an extreme code on signed overflow.
module sat_addsub_clamp #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0]    wrap_sum,
  input  logic                ovf,
  input  logic                a_msb,
  input  sat_addsub_pkg::mode_e mode,
  output logic [WIDTH-1:0]    res
);
  localparam logic [WIDTH-1:0] POS_LIMIT = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] NEG_LIMIT = {1'b1, {(WIDTH-1){1'b0}}};

  always_comb begin
    if (mode == sat_addsub_pkg::MODE_CLAMP && ovf)
      res = a_msb ? NEG_LIMIT : POS_LIMIT;
    else
      res = wrap_sum;
  end
endmodule

// File: rtl/sat_addsub.sv
module sat_addsub #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic             op_sub,
  input  logic             sat_en,
  output logic [WIDTH-1:0] res,
  output logic             cout,
  output logic             ovf
);
  import sat_addsub_pkg::*;

  op_e             op;
  mode_e           mode;
  logic [WIDTH-1:0] b_eff;
  logic             c_in;
  logic [WIDTH-1:0] wrap_sum;
  logic             c_top_in;
  logic             c_top_out;

  assign op   = op_e'(op_sub);
  assign mode = mode_e'(sat_en);

  sat_addsub_bprep #(.WIDTH(WIDTH)) u_bprep (
    .b_in(opnd_b), .op(op), .b_eff(b_eff), .c_in(c_in)
  );

  sat_addsub_chain #(.WIDTH(WIDTH)) u_chain (
    .x(opnd_a), .y(b_eff), .c_in(c_in),
    .sum(wrap_sum), .c_top_in(c_top_in), .c_top_out(c_top_out)
  );

  assign ovf  = c_top_in ^ c_top_out;
  assign cout = c_top_out;

  sat_addsub_clamp #(.WIDTH(WIDTH)) u_clamp (
    .wrap_sum(wrap_sum), .ovf(ovf), .a_msb(opnd_a[WIDTH-1]),
    .mode(mode), .res(res)
  );
endmodule

// File: rtl/sat_addsub_chk.sv
module sat_addsub_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic             op_sub,
  input logic             sat_en,
  input logic [WIDTH-1:0] res,
  input logic             cout,
  input logic             ovf
);
  logic signed [WIDTH:0] wide;
  logic [WIDTH:0]        uwide;
  logic                  ovf_ref;
  logic [WIDTH-1:0]      wrap_ref;

  always_comb begin
    wide  = op_sub ? ($signed({opnd_a[WIDTH-1], opnd_a}) - $signed({opnd_b[WIDTH-1], opnd_b}))
                   : ($signed({opnd_a[WIDTH-1], opnd_a}) + $signed({opnd_b[WIDTH-1], opnd_b}));
    uwide = op_sub ? ({1'b0, opnd_a} - {1'b0, opnd_b}) : ({1'b0, opnd_a} + {1'b0, opnd_b});
    ovf_ref  = wide[WIDTH] ^ wide[WIDTH-1];
    wrap_ref = wide[WIDTH-1:0];
    if (!$isunknown({opnd_a, opnd_b, op_sub, sat_en})) begin
      AST_WRAP_VALUE: assert (sat_en || res == wrap_ref) else $error("wrap value"); // R1
      AST_CARRY_OUT: assert (cout == (op_sub ? ~uwide[WIDTH] : uwide[WIDTH])) else $error("carry"); // R3
      AST_SIGNED_OVF: assert (ovf == ovf_ref) else $error("overflow flag"); // R4
      AST_CLAMP_EDGE: assert (!(sat_en && ovf) || res == (opnd_a[WIDTH-1] ? {1'b1, {(WIDTH-1){1'b0}}} : {1'b0, {(WIDTH-1){1'b1}}})) else $error("clamp"); // R7
      AST_CLAMP_PASS: assert (!(sat_en && !ovf) || res == wrap_ref) else $error("clamp pass"); // R8
    end
  end
endmodule

bind sat_addsub sat_addsub_chk #(.WIDTH(WIDTH)) u_chk (
  .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sub(op_sub), .sat_en(sat_en),
  .res(res), .cout(cout), .ovf(ovf)
);

// File: tb/tb_sat_addsub.sv
`timescale 1ns/1ps
module tb_sat_addsub;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [7:0]  a8, b8, r8;
  logic [11:0] a12, b12, r12;
  logic        sub, sat, c8, v8, c12, v12;

  sat_addsub #(.WIDTH(8)) dut (
    .opnd_a(a8), .opnd_b(b8), .op_sub(sub), .sat_en(sat),
    .res(r8), .cout(c8), .ovf(v8)
  );
  sat_addsub #(.WIDTH(12)) dut12 (
    .opnd_a(a12), .opnd_b(b12), .op_sub(sub), .sat_en(sat),
    .res(r12), .cout(c12), .ovf(v12)
  );

  // Reference model computed from the requirements with integer arithmetic.
  task automatic ref_model(input int w, input longint a, input longint b, input bit s,
                           input bit m, output longint r, output bit c, output bit v);
    longint mask, sa, sb, full, hi, lo;
    mask = (64'sd1 <<< w) - 1;
    hi   = (64'sd1 <<< (w - 1)) - 1;
    lo   = -(64'sd1 <<< (w - 1));
    sa   = (a > hi) ? a - (mask + 1) : a;
    sb   = (b > hi) ? b - (mask + 1) : b;
    full = s ? sa - sb : sa + sb;
    v    = (full > hi) || (full < lo);
    c    = s ? (a >= b) : ((a + b) > mask);
    if (m && v) r = (sa < 0) ? (lo & mask) : hi;
    else        r = full & mask;
  endtask

  task automatic check(input int w, input longint a, input longint b, input bit s,
                       input bit m, input string req);
    longint er, ar; bit ec, ev, ac, av;
    if (w == 8) begin a8 = a[7:0]; b8 = b[7:0]; end
    else        begin a12 = a[11:0]; b12 = b[11:0]; end
    sub = s; sat = m;
    #1;
    ref_model(w, a, b, s, m, er, ec, ev);
    if (w == 8) begin ar = longint'(r8); ac = c8; av = v8; end
    else        begin ar = longint'(r12); ac = c12; av = v12; end
    n_run++;
    if (ar != er || ac != ec || av != ev) begin
      n_fail++;
      $display("FAIL %s w=%0d a=%0h b=%0h sub=%0b sat=%0b: got res=%0h c=%0b v=%0b exp res=%0h c=%0b v=%0b",
               req, w, a, b, s, m, ar, ac, av, er, ec, ev);
    end
  endtask

  task automatic t_reset_idle();
    a8 = 0; b8 = 0; a12 = 0; b12 = 0; sub = 0; sat = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(8, 0, 0, 0, 0, "R1 idle");
    rst = 1'b0;
  endtask

  task automatic t_doc_case();   // R5
    check(8, 'hB4, 'h9A, 0, 0, "R5");
    if (r8 !== 8'h4E || v8 !== 1'b1) begin
      n_fail++; $display("FAIL R5 res=%0h v=%0b exp 4e 1", r8, v8);
    end
    n_run++;
  endtask

  task automatic t_negate_min(); // R6
    check(8, 0, 'h80, 1, 0, "R6");
    if (r8 !== 8'h80 || v8 !== 1'b1) begin
      n_fail++; $display("FAIL R6 res=%0h v=%0b exp 80 1", r8, v8);
    end
    n_run++;
    check(12, 0, 'h800, 1, 0, "R6");
  endtask

  task automatic t_clamp12();    // R10, R9
    check(12, 'h7FF, 1, 0, 1, "R10");
    if (r12 !== 12'h7FF || v12 !== 1'b1) begin
      n_fail++; $display("FAIL R10/R9 res=%0h v=%0b exp 7ff 1", r12, v12);
    end
    n_run++;
    check(12, 'h800, 1, 1, 1, "R10");
    if (r12 !== 12'h800 || v12 !== 1'b1) begin
      n_fail++; $display("FAIL R10/R9 res=%0h v=%0b exp 800 1", r12, v12);
    end
    n_run++;
    check(12, 'h400, 'h3FF, 0, 1, "R8");
    check(12, 'h123, 'hF00, 1, 0, "R2");
  endtask

  task automatic t_sweep8();     // R1 R2 R3 R4 R7 R8 R9
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        for (int s = 0; s < 2; s++)
          for (int m = 0; m < 2; m++)
            check(8, a, b, s[0], m[0], s[0] ? (m[0] ? "R7" : "R2") : (m[0] ? "R8" : "R1"));
  endtask

  initial begin
    t_reset_idle();
    t_doc_case();
    t_negate_min();
    t_clamp12();
    t_sweep8();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule